// File: doc/BRIEF.md
# DMA Virtual Address Translator

This block sits between a bus-mastering device and the memory system. It turns the virtual addresses a device uses for DMA into physical addresses. A device hands over one request at a time: a start address, a byte count, a direction and the slot it occupies. The block then walks the request one 4 KB page at a time. For each page it computes where that page's 32-bit table entry lives, reads the entry through a memory read port, checks it, and emits a physical sub-transfer that never crosses a page boundary.

The translation window and the table base come from a register bank outside this block. The window is given as the lowest address of the window, and the address is masked with its inverse before indexing. Each slot can also be set to bypass translation. In that case its addresses are used as physical directly, with bit 30 replaced by a per-slot setting. A bad entry ends the request with a fault pulse that carries the virtual address and a cause code. A request that completes cleanly ends with a done pulse.

Top module: `dma_xlate`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is accepted on a cycle with `req_valid` and `req_ready` both high. From then until its done or fault pulse, `req_ready` stays low and no new request is taken.
- R2: For a translated chunk at virtual address A, the table read address is `(cfg_base << 4) + ({((A & ~cfg_win_start) >> 10)} with bits 1:0 forced to zero)`, all in 32 bits.
- R3: `mem_req_valid` stays high, with `mem_req_addr` unchanged, until `mem_req_ready` is seen. The block then waits for `mem_rsp_valid` before it acts on `mem_rsp_data`.
- R4: A translated sub-transfer's physical address is `((entry & 32'h07FF_FF00) << 4) + A[11:0]`. In the entry, bits 26:8 are the physical page, bit 7 is cacheable, bit 2 is writable and bit 1 is valid. `xfer_cache` copies entry bit 7 and `xfer_write` copies the request direction.
- R5: Each sub-transfer runs from the current address to the end of its 4 KB page or to the end of the request, whichever comes first. Every chunk has its own table read and check, and `xfer_len` is never 0 and never crosses a page.
- R6: An entry with bit 1 clear raises a one-cycle `fault_valid` with `fault_cause` = 0 and `fault_addr` = that chunk's virtual address. That chunk and all later chunks are dropped, and the block returns to idle without a done pulse.
- R7: On a write request, an entry with bit 2 clear raises `fault_valid` with `fault_cause` = 1 and aborts as in R6. On a read request, bit 2 has no effect.
- R8: When `cfg_bypass[slot]` is set for the accepted slot, no table read occurs. Each chunk's address is the virtual address with bit 30 taken from `cfg_bypass_a30[slot]`. Chunks are split as in R5, and `xfer_cache` is 0.
- R9: After the last chunk of a fault-free request, `done` pulses for one cycle. A zero-length request produces `done` with no table read and no sub-transfer. `done`, `fault_valid` and `xfer_valid` are never high together.
- R10: After reset, `req_ready` is high and `mem_req_valid`, `xfer_valid`, `fault_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Device request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_addr | input | 32 | Virtual start address |
| req_len | input | LEN_W | Byte count |
| req_write | input | 1 | 1 = write to memory, 0 = read |
| req_slot | input | SLOT_W | Requesting slot |
| cfg_base | input | 32 | Table base, shifted left by 4 to form a byte address |
| cfg_win_start | input | 32 | Lowest address of the translation window |
| cfg_bypass | input | 2**SLOT_W | Per-slot bypass enable |
| cfg_bypass_a30 | input | 2**SLOT_W | Per-slot value for address bit 30 in bypass |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Table read accepted |
| mem_req_addr | output | 32 | Table entry byte address |
| mem_rsp_valid | input | 1 | Table read data present |
| mem_rsp_data | input | 32 | Table entry |
| xfer_valid | output | 1 | Physical sub-transfer pulse |
| xfer_addr | output | 32 | Physical address |
| xfer_len | output | 13 | Sub-transfer byte count (1 to 4096) |
| xfer_write | output | 1 | Direction of the sub-transfer |
| xfer_cache | output | 1 | Cacheable flag from the entry |
| fault_valid | output | 1 | Fault pulse |
| fault_addr | output | 32 | Virtual address of the faulting chunk |
| fault_cause | output | 1 | 0 = invalid entry, 1 = write to read-only page |
| done | output | 1 | Request finished without fault |

## Verification
The hardest case to reach from the ports is a fault on a later chunk of a multi-page request. Reaching it needs a first page whose entry passes, a table read address that lands on a failing entry, and a start offset near the end of a page. The bench builds a small table in which valid and writable bits follow two different periods. It then sweeps every start page against start offsets at both ends of a page, lengths of up to three pages, both directions and two upper address prefixes. This places faults on the first, second and third chunk, for both causes. The memory model holds off `mem_req_ready` on a repeating pattern, so the hold rule is tested under stalls.

// File: rtl/dma_xlate.sv
`timescale 1ns/1ps
module dma_xlate #(
  parameter int LEN_W  = 16,
  parameter int SLOT_W = 2,
  localparam int NSLOT = 1 << SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [31:0]       cfg_base,
  input  logic [31:0]       cfg_win_start,
  input  logic [NSLOT-1:0]  cfg_bypass,
  input  logic [NSLOT-1:0]  cfg_bypass_a30,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              xfer_valid,
  output logic [31:0]       xfer_addr,
  output logic [12:0]       xfer_len,
  output logic              xfer_write,
  output logic              xfer_cache,
  output logic              fault_valid,
  output logic [31:0]       fault_addr,
  output logic              fault_cause,
  output logic              done
);
  typedef enum logic [1:0] {S_IDLE, S_NEXT, S_FETCH, S_WAIT} st_t;

  st_t               st;
  logic [31:0]       cur;
  logic [LEN_W-1:0]  rem;
  logic              wr;
  logic [SLOT_W-1:0] slot;

  logic [12:0] pg_left;
  logic [12:0] chunk;
  logic [31:0] idx;
  logic [31:0] ppa;
  logic        byp;

  assign pg_left = 13'h1000 - {1'b0, cur[11:0]};
  assign chunk   = (rem < LEN_W'(pg_left)) ? 13'(rem) : pg_left;
  assign idx     = (cur & ~cfg_win_start) >> 10;
  assign byp     = cfg_bypass[slot];
  assign ppa     = ((mem_rsp_data & 32'h07FF_FF00) << 4) + {20'd0, cur[11:0]};

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_FETCH);
  assign mem_req_addr  = (cfg_base << 4) + {idx[31:2], 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cur         <= '0;
      rem         <= '0;
      wr          <= 1'b0;
      slot        <= '0;
      xfer_valid  <= 1'b0;
      xfer_addr   <= '0;
      xfer_len    <= '0;
      xfer_write  <= 1'b0;
      xfer_cache  <= 1'b0;
      fault_valid <= 1'b0;
      fault_addr  <= '0;
      fault_cause <= 1'b0;
      done        <= 1'b0;
    end else begin
      xfer_valid  <= 1'b0;
      fault_valid <= 1'b0;
      done        <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          cur  <= req_addr;
          rem  <= req_len;
          wr   <= req_write;
          slot <= req_slot;
          st   <= S_NEXT;
        end
        S_NEXT: begin
          if (rem == '0) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (byp) begin
            xfer_valid <= 1'b1;
            xfer_addr  <= {cur[31], cfg_bypass_a30[slot], cur[29:0]};
            xfer_len   <= chunk;
            xfer_write <= wr;
            xfer_cache <= 1'b0;
            cur        <= cur + 32'(chunk);
            rem        <= rem - LEN_W'(chunk);
          end else begin
            st <= S_FETCH;
          end
        end
        S_FETCH: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_data[1] || (wr && !mem_rsp_data[2])) begin
            fault_valid <= 1'b1;
            fault_addr  <= cur;
            fault_cause <= mem_rsp_data[1];
            st          <= S_IDLE;
          end else begin
            xfer_valid <= 1'b1;
            xfer_addr  <= ppa;
            xfer_len   <= chunk;
            xfer_write <= wr;
            xfer_cache <= mem_rsp_data[7];
            cur        <= cur + 32'(chunk);
            rem        <= rem - LEN_W'(chunk);
            st         <= S_NEXT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_xlate_sva.sv
`timescale 1ns/1ps
module dma_xlate_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        xfer_valid,
  input logic [31:0] xfer_addr,
  input logic [12:0] xfer_len,
  input logic        fault_valid,
  input logic        done
);
  assert_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !xfer_valid));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_inpage_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (xfer_len != 13'd0 && ({1'b0, xfer_addr[11:0]} + xfer_len) <= 13'h1000));

  assert_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> req_ready);

  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done, fault_valid, xfer_valid}) <= 1);
endmodule

bind dma_xlate dma_xlate_sva u_sva (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .xfer_valid(xfer_valid),
  .xfer_addr(xfer_addr), .xfer_len(xfer_len),
  .fault_valid(fault_valid), .done(done)
);

// File: tb/dma_xlate_tb.sv
`timescale 1ns/1ps
module dma_xlate_tb;
  localparam int LEN_W = 16;
  localparam int SLOT_W = 2;
  localparam logic [31:0] BASE = 32'h0010_0000;
  localparam logic [31:0] TBL  = BASE << 4;
  localparam logic [31:0] WIN  = 32'hFF00_0000;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic req_ready;
  logic [31:0] req_addr = 0;
  logic [LEN_W-1:0] req_len = 0;
  logic [SLOT_W-1:0] req_slot = 0;
  logic [3:0] cfg_bypass = 4'b1010, cfg_a30 = 4'b0010;
  logic mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_rsp_data;
  logic xfer_valid, xfer_write, xfer_cache, fault_valid, fault_cause, done;
  logic [31:0] xfer_addr, fault_addr;
  logic [12:0] xfer_len;

  dma_xlate #(.LEN_W(LEN_W), .SLOT_W(SLOT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_write(req_write), .req_slot(req_slot),
    .cfg_base(BASE), .cfg_win_start(WIN), .cfg_bypass(cfg_bypass), .cfg_bypass_a30(cfg_a30),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .xfer_write(xfer_write), .xfer_cache(xfer_cache), .fault_valid(fault_valid),
    .fault_addr(fault_addr), .fault_cause(fault_cause), .done(done));

  int n_chk = 0, n_err = 0;

  function automatic logic [31:0] pte(int i);
    logic [18:0] ppn = 19'(i * 7 + 3);
    logic v = (i % 5) != 4;
    logic w = (i % 3) != 2;
    logic c = i[0];
    return {5'd0, ppn, c, 4'd0, w, v, 1'b0};
  endfunction

  function automatic logic [31:0] lookup(logic [31:0] a);
    logic [31:0] k = (a - TBL) >> 2;
    if (k < 32) return pte(int'(k));
    return 32'd0;
  endfunction

  // memory model: ready stalls on a pattern, response one cycle after acceptance
  logic [31:0] fetch_log [0:7];
  int n_fetch = 0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= lookup(mem_req_addr);
      if (n_fetch < 8) fetch_log[n_fetch] <= mem_req_addr;
      n_fetch <= n_fetch + 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(logic [31:0] addr, int len, logic wr, logic [1:0] slot);
    logic [31:0] ex_a [0:7]; logic [12:0] ex_l [0:7]; logic ex_c [0:7];
    logic [31:0] ex_f [0:7];
    logic [31:0] ob_a [0:7]; logic [12:0] ob_l [0:7]; logic ob_c [0:7]; logic ob_w [0:7];
    int nx = 0, nf = 0, no = 0;
    logic ex_fault = 0, ex_cause = 0, got_fault = 0, got_cause = 0, got_done = 0;
    logic busy_bad = 0;
    logic [31:0] ex_faddr = 0, got_faddr = 0;
    logic [31:0] a = addr;
    int r = len;
    bit fin = 0;
    while (r > 0 && !ex_fault) begin
      int pg = 4096 - int'(a[11:0]);
      int c = (r < pg) ? r : pg;
      if (cfg_bypass[slot]) begin
        ex_a[nx] = {a[31], cfg_a30[slot], a[29:0]}; ex_l[nx] = 13'(c); ex_c[nx] = 0; nx++;
      end else begin
        logic [31:0] pa = TBL + (((a & ~WIN) >> 10) & ~32'd3);
        logic [31:0] e = lookup(pa);
        ex_f[nf] = pa; nf++;
        if (!e[1]) begin ex_fault = 1; ex_cause = 0; ex_faddr = a; end
        else if (wr && !e[2]) begin ex_fault = 1; ex_cause = 1; ex_faddr = a; end
        else begin
          ex_a[nx] = ((e & 32'h07FF_FF00) << 4) + {20'd0, a[11:0]};
          ex_l[nx] = 13'(c); ex_c[nx] = e[7]; nx++;
        end
      end
      a = a + 32'(c); r = r - c;
    end
    @(negedge clk);
    n_fetch = 0;
    req_valid = 1; req_addr = addr; req_len = LEN_W'(len); req_write = wr; req_slot = slot;
    @(negedge clk);
    req_valid = 0;
    for (int t = 0; t < 2000 && !fin; t++) begin
      if (req_ready && !done && !fault_valid) busy_bad = 1;
      if (xfer_valid) begin
        if (no < 8) begin ob_a[no] = xfer_addr; ob_l[no] = xfer_len; ob_c[no] = xfer_cache; ob_w[no] = xfer_write; end
        no++;
      end
      if (fault_valid) begin got_fault = 1; got_cause = fault_cause; got_faddr = fault_addr; fin = 1; end
      if (done) begin got_done = 1; fin = 1; end
      if (!fin) @(negedge clk);
    end
    if (!fin) chk("watchdog R9 request never ended", 0, 1);
    chk("R1 ready low while busy", 32'(busy_bad), 0);
    chk("R5 sub-transfer count", no, nx);
    for (int i = 0; i < nx && i < no; i++) begin
      chk(cfg_bypass[slot] ? "R8 bypass address" : "R4 physical address", ob_a[i], ex_a[i]);
      chk("R5 chunk length", 32'(ob_l[i]), 32'(ex_l[i]));
      chk("R4 cache flag", 32'(ob_c[i]), 32'(ex_c[i]));
      chk("R4 direction", 32'(ob_w[i]), 32'(wr));
    end
    chk(cfg_bypass[slot] ? "R8 no table read" : "R3 table read count", n_fetch, nf);
    for (int i = 0; i < nf && i < n_fetch && i < 8; i++)
      chk("R2 entry address", fetch_log[i], ex_f[i]);
    chk(ex_cause ? "R7 fault flag" : "R6 fault flag", 32'(got_fault), 32'(ex_fault));
    if (ex_fault) begin
      chk(ex_cause ? "R7 fault cause" : "R6 fault cause", 32'(got_cause), 32'(ex_cause));
      chk("R6 fault address", got_faddr, ex_faddr);
    end
    chk("R9 done", 32'(got_done), 32'(!ex_fault));
  endtask

  initial begin
    #(20 * 190000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int offs [4] = '{0, 4, 12'hFF0, 12'hFFC};
    int lens [5] = '{0, 1, 16, 4096, 8200};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 req_ready", 32'(req_ready), 1);
    chk("R10 mem_req_valid", 32'(mem_req_valid), 0);
    chk("R10 xfer_valid", 32'(xfer_valid), 0);
    chk("R10 fault/done", 32'({fault_valid, done}), 0);
    for (int h = 0; h < 2; h++)
      for (int p = 0; p < 12; p++)
        for (int o = 0; o < 4; o++)
          for (int l = 0; l < 5; l++)
            for (int w = 0; w < 2; w++)
              run({(h == 0) ? 8'hFF : 8'h3F, 12'(p), 12'(offs[o])}, lens[l], w[0], (p % 4 == 3) ? 2'd2 : 2'd0);
    for (int s = 1; s < 4; s += 2)
      for (int o = 0; o < 4; o++)
        for (int l = 0; l < 5; l++)
          run({8'hBF, 12'(o * 5), 12'(offs[o])}, lens[l], o[0], 2'(s));
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule